// File: doc/BRIEF.md
# Decryption Context Region Selector

This block sits beside an inline decryption engine in front of a memory bus. It holds a small table of address contexts that software programs through a simple register port. Each context describes a window of the address space, at 1 KB granularity, together with a 128-bit key, a 64-bit counter and three flags: valid, decrypt-enable and read-only.

For every bus address presented on the lookup port, all contexts are compared in parallel. The result is registered one cycle later. When exactly one valid context covers the address, the block forwards that context's index, key, counter and flags to the decryption datapath. When none or several cover it, a region error is raised and no key material is forwarded, so an overlap can never be resolved by priority. A global enable bit turns the whole function off, and then data passes through unchanged. A sticky restricted mode hides the context table from the register port: reads return zero and writes are dropped, while lookups keep using the stored contents.

Register map. The control word is at byte offset 0x00: bit 0 is the global enable, and writing 1 to bit 1 enters restricted mode. The status word is at 0x04 and is read-only: bit 0 is the restricted flag. Context n occupies the 32 bytes starting at 0x20*(n+1). Within that window the words are:

- +0x00: region start. Bits [31:10] hold the start granule.
- +0x04: region end. Bits [31:10] hold the end granule, bit 2 is valid, bit 1 is decrypt-enable and bit 0 is read-only.
- +0x08 to +0x14: key words 0 to 3, least significant word first.
- +0x18 and +0x1C: counter words 0 and 1, least significant word first.

Top module: `dec_region_select`

## Requirements
- R1: After reset, the global enable, the restricted flag, every context word and every lookup output read as zero.
- R2: Context words read back what was written. In the start word only bits [31:10] are kept. In the end word only bits [31:10] and bits [2:0] are kept, and all other bits read as zero.
- R3: A context hits an address only when its valid bit (end word bit 2) is set and start ≤ addr[31:10] ≤ end, with both bounds inclusive. Address bits [9:0] are ignored.
- R4: With the global enable set, a lookup that hits exactly one context produces out_hit=1 one cycle later. In that cycle out_idx, out_key, out_ctr, out_dec_en (end word bit 1) and out_ro (end word bit 0) all come from that context.
- R5: With the global enable set, a lookup that hits zero contexts, or two or more, produces out_region_err=1 and out_hit=0 one cycle later. In that cycle out_idx, out_key, out_ctr, out_dec_en and out_ro are all zero.
- R6: A context whose start granule is greater than its end granule never hits any address.
- R7: While the global enable is clear, a lookup produces out_hit=0, out_dec_en=0 and out_region_err=0.
- R8: Writing 1 to control bit 1 sets the restricted status bit. That bit stays set until reset, whatever is written afterwards.
- R9: While the restricted flag is set, context words read as zero and writes to them are ignored. Lookups keep using the contents stored before restricted mode began.
- R10: out_valid equals lk_valid delayed by one cycle. When lk_valid was low, out_hit, out_region_err and out_dec_en are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_valid | input | 1 | Lookup address valid |
| lk_addr | input | 32 | Lookup bus address |
| out_valid | output | 1 | Lookup result valid |
| out_hit | output | 1 | Exactly one context hit |
| out_region_err | output | 1 | Zero or multiple contexts hit |
| out_idx | output | 2 | Index of the selected context |
| out_key | output | 128 | Key of the selected context |
| out_ctr | output | 64 | Counter of the selected context |
| out_dec_en | output | 1 | Decryption enabled for this access |
| out_ro | output | 1 | Selected context is read-only |

## Verification
The assertions assume that the lookup inputs and the register strobes change only between clock edges. They also assume that no register write lands in the same cycle as a lookup whose result is being judged against the table; otherwise the comparison would see a half-updated context. The stimulus drives every input on the falling edge and keeps register writes and lookups in separate cycles. It also leaves the lookup valid low between accesses, so each result cycle belongs to exactly one address.

// File: rtl/dec_region_pkg.sv
package dec_region_pkg;
  localparam int ADDR_W   = 32;
  localparam int GRAN_LSB = 10;
  localparam int GRAN_W   = ADDR_W - GRAN_LSB;
  localparam int WORD_W   = 32;
  localparam int KEY_W    = 128;
  localparam int CTR_W    = 64;

  typedef enum logic [2:0] {
    WD_START = 3'd0,
    WD_END   = 3'd1,
    WD_KEY0  = 3'd2,
    WD_KEY1  = 3'd3,
    WD_KEY2  = 3'd4,
    WD_KEY3  = 3'd5,
    WD_CTR0  = 3'd6,
    WD_CTR1  = 3'd7
  } ctx_word_e;

  typedef struct packed {
    logic [GRAN_W-1:0] lo;
    logic [GRAN_W-1:0] hi;
    logic              vld;
    logic              dec;
    logic              ro;
    logic [KEY_W-1:0]  key;
    logic [CTR_W-1:0]  ctr;
  } ctx_t;

  localparam int CTX_BITS = $bits(ctx_t);

  // 1 KB granule of a bus address
  function automatic logic [GRAN_W-1:0] addr_gran(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:GRAN_LSB];
  endfunction

  // inclusive window test, gated by valid
  function automatic logic ctx_hits(input ctx_t c, input logic [GRAN_W-1:0] g);
    return c.vld && (c.lo <= g) && (g <= c.hi);
  endfunction

  function automatic logic [WORD_W-1:0] start_word(input ctx_t c);
    return {c.lo, {GRAN_LSB{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] end_word(input ctx_t c);
    return {c.hi, {(GRAN_LSB-3){1'b0}}, c.vld, c.dec, c.ro};
  endfunction
endpackage

// File: rtl/dec_region_ctrl.sv
module dec_region_ctrl #(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              glob_en,
  output logic              restricted,
  output logic              ctrl_sel,
  output logic [31:0]       ctrl_rdata
);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(4);

  logic wr_ctrl;
  logic unused_wbits;

  assign wr_ctrl      = reg_wr && (reg_addr == A_CTRL);
  assign unused_wbits = ^reg_wdata[31:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en    <= 1'b0;
      restricted <= 1'b0;
    end else if (wr_ctrl) begin
      glob_en <= reg_wdata[0];
      if (reg_wdata[1]) restricted <= 1'b1;
    end
  end

  always_comb begin
    ctrl_sel   = (reg_addr == A_CTRL) || (reg_addr == A_STAT);
    ctrl_rdata = '0;
    if (reg_addr == A_CTRL) ctrl_rdata = {30'b0, restricted, glob_en};
    else if (reg_addr == A_STAT) ctrl_rdata = {31'b0, restricted};
  end
endmodule

// File: rtl/dec_region_table.sv
module dec_region_table
  import dec_region_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int REG_AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              restricted,
  output ctx_t              ctx_o [NUM_CTX],
  output logic              tbl_sel,
  output logic              tbl_we_any,
  output logic [31:0]       tbl_rdata
);
  localparam int PAGE_W = REG_AW - 5;

  logic [PAGE_W-1:0] page;
  ctx_word_e         word;
  logic [NUM_CTX-1:0] we;
  logic              unused_alow;

  assign page        = reg_addr[REG_AW-1:5];
  assign word        = ctx_word_e'(reg_addr[4:2]);
  assign unused_alow = ^reg_addr[1:0];
  assign tbl_sel     = (page != '0) && (page <= PAGE_W'(NUM_CTX));
  assign tbl_we_any  = |we;

  for (genvar n = 0; n < NUM_CTX; n++) begin : g_ctx
    assign we[n] = reg_wr && !restricted && (page == PAGE_W'(n + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctx_o[n] <= '0;
      end else if (we[n]) begin
        case (word)
          WD_START: ctx_o[n].lo <= reg_wdata[31:GRAN_LSB];
          WD_END: begin
            ctx_o[n].hi  <= reg_wdata[31:GRAN_LSB];
            ctx_o[n].vld <= reg_wdata[2];
            ctx_o[n].dec <= reg_wdata[1];
            ctx_o[n].ro  <= reg_wdata[0];
          end
          WD_KEY0: ctx_o[n].key[31:0]   <= reg_wdata;
          WD_KEY1: ctx_o[n].key[63:32]  <= reg_wdata;
          WD_KEY2: ctx_o[n].key[95:64]  <= reg_wdata;
          WD_KEY3: ctx_o[n].key[127:96] <= reg_wdata;
          WD_CTR0: ctx_o[n].ctr[31:0]   <= reg_wdata;
          WD_CTR1: ctx_o[n].ctr[63:32]  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    tbl_rdata = '0;
    for (int n = 0; n < NUM_CTX; n++) begin
      if (!restricted && (page == PAGE_W'(n + 1))) begin
        case (word)
          WD_START: tbl_rdata = start_word(ctx_o[n]);
          WD_END:   tbl_rdata = end_word(ctx_o[n]);
          WD_KEY0:  tbl_rdata = ctx_o[n].key[31:0];
          WD_KEY1:  tbl_rdata = ctx_o[n].key[63:32];
          WD_KEY2:  tbl_rdata = ctx_o[n].key[95:64];
          WD_KEY3:  tbl_rdata = ctx_o[n].key[127:96];
          WD_CTR0:  tbl_rdata = ctx_o[n].ctr[31:0];
          WD_CTR1:  tbl_rdata = ctx_o[n].ctr[63:32];
          default:  tbl_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dec_region_match.sv
module dec_region_match
  import dec_region_pkg::*;
#(
  parameter int NUM_CTX = 4,
  localparam int IDX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int CNT_W = $clog2(NUM_CTX + 1)
) (
  input  ctx_t               ctx_i [NUM_CTX],
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CTX-1:0] hit_vec,
  output logic               uniq,
  output logic [IDX_W-1:0]   idx,
  output ctx_t               sel
);
  logic [GRAN_W-1:0] gran;
  logic [CNT_W-1:0]  cnt;

  assign gran = addr_gran(addr);

  for (genvar n = 0; n < NUM_CTX; n++) begin : g_cmp
    assign hit_vec[n] = ctx_hits(ctx_i[n], gran);
  end

  always_comb begin
    cnt = '0;
    idx = '0;
    for (int n = 0; n < NUM_CTX; n++) begin
      if (hit_vec[n]) begin
        cnt = cnt + CNT_W'(1);
        idx = IDX_W'(n);
      end
    end
    uniq = (cnt == CNT_W'(1));
    sel  = uniq ? ctx_i[idx] : '0;
  end
endmodule

// File: rtl/dec_region_select.sv
module dec_region_select
  import dec_region_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int REG_AW  = 8,
  localparam int IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_valid,
  input  logic [31:0]       lk_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_region_err,
  output logic [IDX_W-1:0]  out_idx,
  output logic [127:0]      out_key,
  output logic [63:0]       out_ctr,
  output logic              out_dec_en,
  output logic              out_ro
);
  logic               glob_en, restricted, ctrl_sel, tbl_sel, tbl_we_any;
  logic [31:0]        ctrl_rdata, tbl_rdata;
  ctx_t               ctx_tab [NUM_CTX];
  logic [NUM_CTX-1:0] hit_vec;
  logic               uniq;
  logic [IDX_W-1:0]   idx;
  ctx_t               sel;
  logic [CTX_BITS-1:0] tbl_digest;
  logic               accept;
  logic               unused_sel;

  dec_region_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .glob_en, .restricted, .ctrl_sel, .ctrl_rdata
  );

  dec_region_table #(.NUM_CTX(NUM_CTX), .REG_AW(REG_AW)) u_tab (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .restricted,
    .ctx_o(ctx_tab), .tbl_sel, .tbl_we_any, .tbl_rdata
  );

  dec_region_match #(.NUM_CTX(NUM_CTX)) u_match (
    .ctx_i(ctx_tab), .addr(lk_addr), .hit_vec, .uniq, .idx, .sel
  );

  assign reg_rdata  = ctrl_sel ? ctrl_rdata : tbl_rdata;
  assign accept     = lk_valid && glob_en;
  assign unused_sel = ^{sel.lo, sel.hi, sel.vld, tbl_sel, tbl_we_any};

  // fold of the whole table, watched by the checker
  always_comb begin
    tbl_digest = '0;
    for (int n = 0; n < NUM_CTX; n++) tbl_digest = tbl_digest ^ ctx_tab[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_hit        <= 1'b0;
      out_region_err <= 1'b0;
      out_idx        <= '0;
      out_key        <= '0;
      out_ctr        <= '0;
      out_dec_en     <= 1'b0;
      out_ro         <= 1'b0;
    end else begin
      out_valid      <= lk_valid;
      out_hit        <= accept && uniq;
      out_region_err <= accept && !uniq;
      out_idx        <= (accept && uniq) ? idx : '0;
      out_key        <= accept ? sel.key : '0;
      out_ctr        <= accept ? sel.ctr : '0;
      out_dec_en     <= accept && sel.dec;
      out_ro         <= accept && sel.ro;
    end
  end
endmodule

// File: rtl/dec_region_chk.sv
module dec_region_chk #(
  parameter int NUM_CTX  = 4,
  parameter int DIG_W    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               glob_en,
  input logic               restricted,
  input logic               reg_wr,
  input logic               tbl_sel,
  input logic [31:0]        reg_rdata,
  input logic [DIG_W-1:0]   tbl_digest,
  input logic [NUM_CTX-1:0] hit_vec,
  input logic               out_valid,
  input logic               out_hit,
  input logic               out_region_err,
  input logic               out_dec_en,
  input logic               out_ro
);
  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> out_valid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!out_valid && !out_hit && !out_region_err && !out_dec_en));
  assert_unique_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && glob_en && $countones(hit_vec) == 1) |=> (out_hit && !out_region_err));
  assert_flags_need_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dec_en || out_ro) |-> out_hit);
  assert_nonunique_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && glob_en && $countones(hit_vec) != 1) |=> (out_region_err && !out_hit));
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !glob_en) |=> (!out_hit && !out_dec_en && !out_region_err));
  assert_restrict_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restricted |=> restricted);
  assert_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restricted && tbl_sel) |-> (reg_rdata == 32'h0));
  assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restricted && reg_wr && tbl_sel) |=> $stable(tbl_digest));
endmodule

bind dec_region_select dec_region_chk #(
  .NUM_CTX(NUM_CTX),
  .DIG_W(dec_region_pkg::CTX_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .glob_en(glob_en),
  .restricted(restricted), .reg_wr(reg_wr), .tbl_sel(tbl_sel),
  .reg_rdata(reg_rdata), .tbl_digest(tbl_digest), .hit_vec(hit_vec),
  .out_valid(out_valid), .out_hit(out_hit), .out_region_err(out_region_err),
  .out_dec_en(out_dec_en), .out_ro(out_ro)
);

// File: tb/dec_region_select_tb.sv
module dec_region_select_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         lk_valid = 1'b0;
  logic [31:0]  lk_addr = '0;
  logic         out_valid, out_hit, out_region_err, out_dec_en, out_ro;
  logic [1:0]   out_idx;
  logic [127:0] out_key;
  logic [63:0]  out_ctr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [21:0]  m_lo [4], m_hi [4];
  logic         m_v [4], m_d [4], m_r [4];
  logic [127:0] m_key [4];
  logic [63:0]  m_ctr [4];
  logic         m_en = 0, m_restr = 0;

  always #5 clk = ~clk;

  dec_region_select u_dut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .lk_valid, .lk_addr, .out_valid, .out_hit, .out_region_err,
    .out_idx, .out_key, .out_ctr, .out_dec_en, .out_ro
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] caddr(input int n, input int w);
    return 8'((n + 1) * 32 + w * 4);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (!m_restr && a >= 8'h20 && a < 8'hA0) begin
      int n, w;
      n = int'(a[7:5]) - 1; w = int'(a[4:2]);
      case (w)
        0: m_lo[n] = d[31:10];
        1: begin m_hi[n] = d[31:10]; m_v[n] = d[2]; m_d[n] = d[1]; m_r[n] = d[0]; end
        2, 3, 4, 5: m_key[n][32*(w-2) +: 32] = d;
        default: m_ctr[n][32*(w-6) +: 32] = d;
      endcase
    end
    if (a == 8'h00) begin m_en = d[0]; if (d[1]) m_restr = 1; end
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, 256'(reg_rdata), 256'(exp));
  endtask

  function automatic logic [198:0] model_out(input logic [31:0] a);
    int cnt = 0; int id = 0;
    for (int n = 0; n < 4; n++)
      if (m_v[n] && m_lo[n] <= a[31:10] && a[31:10] <= m_hi[n]) begin cnt++; id = n; end
    if (!m_en) return {1'b1, 198'b0};
    if (cnt != 1) return {1'b1, 1'b0, 1'b1, 196'b0};
    return {1'b1, 1'b1, 1'b0, 2'(id), m_d[id], m_r[id], m_key[id], m_ctr[id]};
  endfunction

  task automatic lookup(input string req, input logic [31:0] a);
    logic [198:0] exp;
    exp = model_out(a);
    @(negedge clk);
    lk_valid = 1; lk_addr = a;
    @(negedge clk);
    lk_valid = 0;
    check(req, 256'({out_valid, out_hit, out_region_err, out_idx, out_dec_en, out_ro, out_key, out_ctr}),
          256'(exp));
  endtask

  task automatic prog_ctx(input int n, input int lo, input int hi, input logic [2:0] fl);
    wr(caddr(n, 0), {22'(lo), 10'h3FF});
    wr(caddr(n, 1), {22'(hi), 7'h7F, fl});
    for (int w = 0; w < 4; w++) wr(caddr(n, 2 + w), {8'hA0 + 8'(n), 8'(w), 16'h5A5A});
    for (int w = 0; w < 2; w++) wr(caddr(n, 6 + w), {8'hC0 + 8'(n), 8'(w), 16'h3C3C});
  endtask

  task automatic t_reset;
    rd_check("R1 ctrl", 8'h00, 32'h0);
    rd_check("R1 status", 8'h04, 32'h0);
    rd_check("R1 ctx end word", caddr(2, 1), 32'h0);
    check("R1 outputs", 256'({out_valid, out_hit, out_region_err, out_dec_en, out_ro, out_key, out_ctr}), 256'(0));
  endtask

  task automatic t_program;
    prog_ctx(0, 'h0, 'h3, 3'b110);
    prog_ctx(1, 'h10, 'h1F, 3'b111);
    prog_ctx(2, 'h18, 'h30, 3'b100);
    prog_ctx(3, 'h100, 'h80, 3'b110);
    rd_check("R2 start masked", caddr(1, 0), 32'h10 << 10);
    rd_check("R2 end masked", caddr(1, 1), (32'h1F << 10) | 32'h7);
    rd_check("R2 key word", caddr(2, 4), 32'hA2025A5A);
    rd_check("R2 ctr word", caddr(3, 7), 32'hC3013C3C);
  endtask

  task automatic t_disabled;
    lookup("R7 disabled hit addr", 32'h0000_0800);
    lookup("R7 disabled overlap addr", 32'h0000_6000);
  endtask

  task automatic t_matches;
    wr(8'h00, 32'h1);
    lookup("R4 unique ctx0", 32'h0000_0800);
    lookup("R3 start bound ctx0", 32'h0000_0000);
    lookup("R3 end bound ctx0", 32'h0000_0FFF);
    lookup("R5 miss above ctx0", 32'h0000_1000);
    lookup("R3 start bound ctx1", 32'h0000_4000);
    lookup("R4 unique ctx1 ro", 32'h0000_5FFF);
    lookup("R5 overlap ctx1 ctx2", 32'h0000_6000);
    lookup("R5 overlap end", 32'h0000_7FFF);
    lookup("R3 end bound ctx2", 32'h0000_C3FF);
    lookup("R5 miss above ctx2", 32'h0000_C400);
    lookup("R6 inverted ctx3", 32'h0002_4000);
    lookup("R6 inverted ctx3 edge", 32'h0004_0000);
    wr(caddr(0, 1), (32'h3 << 10) | 32'h2);
    lookup("R3 invalid ctx0", 32'h0000_0400);
    wr(caddr(0, 1), (32'h3 << 10) | 32'h6);
    lookup("R3 revalid ctx0", 32'h0000_0400);
  endtask

  task automatic t_idle;
    @(negedge clk);
    lk_valid = 0; lk_addr = 32'h0000_0400;
    @(negedge clk);
    check("R10 idle", 256'({out_valid, out_hit, out_region_err, out_dec_en}), 256'(0));
  endtask

  task automatic t_restricted;
    wr(8'h00, 32'h3);
    rd_check("R8 status set", 8'h04, 32'h1);
    rd_check("R9 read zero key", caddr(0, 2), 32'h0);
    rd_check("R9 read zero end", caddr(0, 1), 32'h0);
    wr(caddr(0, 1), 32'h0);
    wr(caddr(0, 2), 32'hDEAD_BEEF);
    lookup("R9 writes ignored", 32'h0000_0C00);
    wr(8'h00, 32'h1);
    rd_check("R8 sticky after clear", 8'h04, 32'h1);
    lookup("R9 lookup still served", 32'h0000_4400);
  endtask

  initial begin
    for (int n = 0; n < 4; n++) begin
      m_lo[n] = 0; m_hi[n] = 0; m_v[n] = 0; m_d[n] = 0; m_r[n] = 0; m_key[n] = 0; m_ctr[n] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_program;
    t_disabled;
    t_matches;
    t_idle;
    t_restricted;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule